// File: doc/BRIEF.md
# Fetch-Stage Branch Target Predictor with Return Stack

This block sits beside the instruction fetch address and answers, combinationally in the same cycle, whether the address being fetched is a known branch, whether that branch is expected to be taken, and which address fetch should use next. The prediction store is a direct-mapped table indexed by low-order PC bits. Each slot keeps a tag made from the upper PC bits, a taken-path target, a two-bit saturating direction counter and a flag that marks return instructions. The tag is compared on every lookup, so one branch never uses a target that belongs to another branch.

Slots marked as returns do not use their stored target. Their target comes from a small stack of return addresses. A call pushes the address that follows it, and a fetch that hits a return slot pops that address. Resolved branches are written back through a separate update port. It refreshes the counter, target and return flag of a matching slot, and it claims a slot only for a taken branch.

Top module: `btb_ras_predictor`

## Requirements
- R1: After reset every slot is invalid, so every lookup misses until an update claims a slot.
- R2: On a miss, or when `fetch_valid` is low, the outputs in the same cycle are `pred_hit`=0, `pred_taken`=0, `pred_is_ret`=0 and `pred_target`=`fetch_pc`+4.
- R3: A slot is indexed by `fetch_pc[7:2]` (default sizes) and holds the bits above as a tag. A fetch whose index matches but whose tag differs misses.
- R4: An update that does not match a valid slot claims one only when `upd_taken`=1. A not-taken update to an unknown branch leaves later lookups of that PC missing.
- R5: A newly claimed slot starts with counter value 2 (weakly taken). The next lookup of that PC hits, predicts taken and returns `upd_target`.
- R6: The counter counts up on a taken update and down on a not-taken one, saturating at 0 and 3. A hit predicts taken when the counter is 2 or 3, with the stored target. Otherwise it predicts not taken with `fetch_pc`+4.
- R7: A hit on a slot whose return flag is set, with a non-empty stack, gives `pred_hit`=1, `pred_taken`=1, `pred_is_ret`=1, and the stack top as the target. That fetch pops the stack.
- R8: `call_valid` pushes `call_pc`+4. Returns take the addresses back in last-in, first-out order.
- R9: A return-slot hit while the stack is empty counts as a miss (R2 outputs), and the stack stays unchanged.
- R10: The stack holds 8 addresses. A push onto a full stack overwrites the oldest address. After 9 pushes, 8 pops return the 8 newest addresses and the next return misses.
- R11: When a lookup and an update touch the same slot in one cycle, the lookup sees the slot contents from before the update.
- R12: A push and a return pop in the same cycle predict from the old top, and the pushed address replaces it. The stack depth is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | A lookup is made this cycle |
| fetch_pc | input | 32 | Address being fetched |
| pred_hit | output | 1 | Lookup found a usable prediction |
| pred_taken | output | 1 | Branch predicted taken |
| pred_is_ret | output | 1 | Target taken from the return stack |
| pred_target | output | 32 | Next fetch address |
| call_valid | input | 1 | A call was seen; push its return address |
| call_pc | input | 32 | Address of the call |
| upd_valid | input | 1 | A resolved branch is reported |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Resolved direction |
| upd_target | input | 32 | Resolved taken-path target |
| upd_is_ret | input | 1 | The resolved branch is a return |

## Verification
A slot with a corrupted tag or valid bit shows up as a wrong `pred_hit` on the very next lookup of that PC. A counter that steps or saturates wrongly stays hidden until the second or third update in a row, so the counter sequences walk the full 0 to 3 range and back. A stack pointer or occupancy error appears only when returns are fetched. It shows as a wrong target on a pop, or as a hit or miss one pop earlier or later than expected. For that reason the overflow and push-with-pop cases drain the stack completely and check the final empty miss.

// File: rtl/bpred_pkg.sv
package bpred_pkg;

   typedef logic [1:0] dir_ctr_t;

   localparam dir_ctr_t CTR_WEAK_TAKEN = 2'd2;
   localparam dir_ctr_t CTR_MAX        = 2'd3;
   localparam dir_ctr_t CTR_MIN        = 2'd0;

   function automatic dir_ctr_t ctr_step(input dir_ctr_t cur, input logic taken);
      dir_ctr_t nxt;
      nxt = cur;
      if (taken && cur != CTR_MAX)
         nxt = cur + 2'd1;
      else if (!taken && cur != CTR_MIN)
         nxt = cur - 2'd1;
      return nxt;
   endfunction

   function automatic logic ctr_says_taken(input dir_ctr_t cur);
      return cur[1];
   endfunction

endpackage

// File: rtl/bpred_table.sv
module bpred_table
   import bpred_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_idx,
   input  logic [ADDR_W-IDX_W-3:0] rd_tag,
   output logic              rd_hit,
   output dir_ctr_t          rd_ctr,
   output logic [ADDR_W-1:0] rd_tgt,
   output logic              rd_ret,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [ADDR_W-IDX_W-3:0] wr_tag,
   input  logic              wr_taken,
   input  logic [ADDR_W-1:0] wr_tgt,
   input  logic              wr_ret
);
   localparam int ENTRIES = 1 << IDX_W;
   localparam int TAG_W   = ADDR_W - IDX_W - 2;

   logic [ENTRIES-1:0] vld_q;
   logic [TAG_W-1:0]   tag_q [ENTRIES];
   logic [ADDR_W-1:0]  tgt_q [ENTRIES];
   dir_ctr_t           ctr_q [ENTRIES];
   logic [ENTRIES-1:0] ret_q;

   // read port: pure combinational view of the registered state
   assign rd_hit = vld_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
   assign rd_ctr = ctr_q[rd_idx];
   assign rd_tgt = tgt_q[rd_idx];
   assign rd_ret = ret_q[rd_idx];

   logic wr_match, wr_alloc, wr_refresh;
   assign wr_match   = vld_q[wr_idx] && (tag_q[wr_idx] == wr_tag);
   assign wr_refresh = wr_en && wr_match;
   assign wr_alloc   = wr_en && !wr_match && wr_taken;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         vld_q <= '0;
      else if (wr_alloc)
         vld_q[wr_idx] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (wr_alloc) begin
         tag_q[wr_idx] <= wr_tag;
         tgt_q[wr_idx] <= wr_tgt;
         ctr_q[wr_idx] <= CTR_WEAK_TAKEN;
         ret_q[wr_idx] <= wr_ret;
      end else if (wr_refresh) begin
         ctr_q[wr_idx] <= ctr_step(ctr_q[wr_idx], wr_taken);
         ret_q[wr_idx] <= wr_ret;
         if (wr_taken)
            tgt_q[wr_idx] <= wr_tgt;
      end
   end

endmodule

// File: rtl/bpred_rstack.sv
module bpred_rstack #(
   parameter int ADDR_W = 32,
   parameter int DEPTH  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [ADDR_W-1:0] push_val,
   input  logic              pop,
   output logic [ADDR_W-1:0] top,
   output logic              empty
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
   localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

   logic [ADDR_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  ptr_q, ptr_inc, ptr_dec;
   logic [CNT_W-1:0]  cnt_q;

   generate
      if ((1 << PTR_W) == DEPTH) begin : g_pow2
         assign ptr_inc = ptr_q + 1'b1;
         assign ptr_dec = ptr_q - 1'b1;
      end else begin : g_mod
         assign ptr_inc = (ptr_q == LAST_PTR) ? '0 : ptr_q + 1'b1;
         assign ptr_dec = (ptr_q == '0) ? LAST_PTR : ptr_q - 1'b1;
      end
   endgenerate

   assign top   = mem[ptr_dec];
   assign empty = (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
         cnt_q <= '0;
      end else begin
         unique case ({push, pop})
            2'b10: begin
               ptr_q <= ptr_inc;
               if (cnt_q != FULL_CNT)
                  cnt_q <= cnt_q + 1'b1;
            end
            2'b01: begin
               ptr_q <= ptr_dec;
               cnt_q <= cnt_q - 1'b1;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (push && !pop)
         mem[ptr_q] <= push_val;
      else if (push && pop)
         mem[ptr_dec] <= push_val;
   end

endmodule

// File: rtl/btb_ras_predictor.sv
module btb_ras_predictor
   import bpred_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int IDX_W     = 6,
   parameter int RAS_DEPTH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fetch_valid,
   input  logic [ADDR_W-1:0] fetch_pc,
   output logic              pred_hit,
   output logic              pred_taken,
   output logic              pred_is_ret,
   output logic [ADDR_W-1:0] pred_target,
   input  logic              call_valid,
   input  logic [ADDR_W-1:0] call_pc,
   input  logic              upd_valid,
   input  logic [ADDR_W-1:0] upd_pc,
   input  logic              upd_taken,
   input  logic [ADDR_W-1:0] upd_target,
   input  logic              upd_is_ret
);
   localparam int TAG_W = ADDR_W - IDX_W - 2;
   localparam logic [ADDR_W-1:0] INSN_BYTES = ADDR_W'(4);

   generate
      if (TAG_W < 1) begin : g_bad_tag
         $error("address too narrow for the chosen index width");
      end
      if (RAS_DEPTH < 2) begin : g_bad_ras
         $error("return stack needs at least two entries");
      end
   endgenerate

   logic [IDX_W-1:0] f_idx, u_idx;
   logic [TAG_W-1:0] f_tag, u_tag;
   logic             upd_pc_unused;

   assign f_idx = fetch_pc[IDX_W+1:2];
   assign f_tag = fetch_pc[ADDR_W-1:IDX_W+2];
   assign u_idx = upd_pc[IDX_W+1:2];
   assign u_tag = upd_pc[ADDR_W-1:IDX_W+2];
   assign upd_pc_unused = ^upd_pc[1:0];

   logic              tb_hit, tb_ret;
   dir_ctr_t          tb_ctr;
   logic [ADDR_W-1:0] tb_tgt;

   bpred_table #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (f_idx),
      .rd_tag   (f_tag),
      .rd_hit   (tb_hit),
      .rd_ctr   (tb_ctr),
      .rd_tgt   (tb_tgt),
      .rd_ret   (tb_ret),
      .wr_en    (upd_valid),
      .wr_idx   (u_idx),
      .wr_tag   (u_tag),
      .wr_taken (upd_taken),
      .wr_tgt   (upd_target),
      .wr_ret   (upd_is_ret)
   );

   logic              rs_pop, rs_empty;
   logic [ADDR_W-1:0] rs_top;

   bpred_rstack #(.ADDR_W(ADDR_W), .DEPTH(RAS_DEPTH)) u_rstack (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (call_valid),
      .push_val (call_pc + INSN_BYTES),
      .pop      (rs_pop),
      .top      (rs_top),
      .empty    (rs_empty)
   );

   logic tag_hit, br_hit, br_taken;
   logic [ADDR_W-1:0] seq_pc;

   assign seq_pc   = fetch_pc + INSN_BYTES;
   assign tag_hit  = fetch_valid && tb_hit;
   assign rs_pop   = tag_hit && tb_ret && !rs_empty;
   assign br_hit   = tag_hit && !tb_ret;
   assign br_taken = br_hit && ctr_says_taken(tb_ctr);

   always_comb begin
      pred_hit    = br_hit || rs_pop;
      pred_is_ret = rs_pop;
      pred_taken  = br_taken || rs_pop;
      if (rs_pop)
         pred_target = rs_top;
      else if (br_taken)
         pred_target = tb_tgt;
      else
         pred_target = seq_pc;
   end

endmodule

// File: rtl/btb_ras_checker.sv
module btb_ras_checker #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              fetch_valid,
   input logic [ADDR_W-1:0] fetch_pc,
   input logic              pred_hit,
   input logic              pred_taken,
   input logic              pred_is_ret,
   input logic [ADDR_W-1:0] pred_target,
   input logic              call_valid,
   input logic [ADDR_W-1:0] call_pc,
   input logic              upd_valid,
   input logic [ADDR_W-1:0] upd_pc,
   input logic              upd_taken,
   input logic              upd_is_ret
);
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

   assert_clean_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !pred_hit);

   assert_miss_falls_through_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !pred_hit |-> (!pred_taken && !pred_is_ret && pred_target == fetch_pc + STEP));

   assert_alloc_then_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && upd_taken && !upd_is_ret) ##1 (fetch_valid && fetch_pc == $past(upd_pc))
      |-> pred_hit);

   assert_not_taken_seq_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pred_hit && !pred_taken) |-> (pred_target == fetch_pc + STEP));

   assert_return_taken_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pred_hit && pred_is_ret) |-> pred_taken);

   assert_latest_push_on_top_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (pred_is_ret && $past(call_valid)) |-> (pred_target == $past(call_pc) + STEP));

endmodule

bind btb_ras_predictor btb_ras_checker #(.ADDR_W(ADDR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .fetch_valid (fetch_valid),
   .fetch_pc    (fetch_pc),
   .pred_hit    (pred_hit),
   .pred_taken  (pred_taken),
   .pred_is_ret (pred_is_ret),
   .pred_target (pred_target),
   .call_valid  (call_valid),
   .call_pc     (call_pc),
   .upd_valid   (upd_valid),
   .upd_pc      (upd_pc),
   .upd_taken   (upd_taken),
   .upd_is_ret  (upd_is_ret)
);

// File: tb/sim_btb_ras_predictor.sv
`timescale 1ns/1ps
module sim_btb_ras_predictor;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fetch_valid = 1'b0;
   logic [31:0] fetch_pc = '0;
   logic        pred_hit, pred_taken, pred_is_ret;
   logic [31:0] pred_target;
   logic        call_valid = 1'b0;
   logic [31:0] call_pc = '0;
   logic        upd_valid = 1'b0;
   logic [31:0] upd_pc = '0;
   logic        upd_taken = 1'b0;
   logic [31:0] upd_target = '0;
   logic        upd_is_ret = 1'b0;

   int n_chk = 0;
   int n_err = 0;
   bit done = 0;

   always #10 clk = ~clk;

   btb_ras_predictor u0 (
      .clk(clk), .rst_n(rst_n),
      .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
      .pred_hit(pred_hit), .pred_taken(pred_taken),
      .pred_is_ret(pred_is_ret), .pred_target(pred_target),
      .call_valid(call_valid), .call_pc(call_pc),
      .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
      .upd_target(upd_target), .upd_is_ret(upd_is_ret)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // all tasks start and end at a falling edge
   task automatic expect_pred(input string req, input logic [31:0] pc,
                              input logic eh, input logic et, input logic er,
                              input logic [31:0] etg);
      fetch_valid = 1'b1;
      fetch_pc    = pc;
      #2;
      chk(req, "hit", 32'(pred_hit), 32'(eh));
      chk(req, "taken", 32'(pred_taken), 32'(et));
      chk(req, "is_ret", 32'(pred_is_ret), 32'(er));
      chk(req, "target", pred_target, etg);
      @(negedge clk);
      fetch_valid = 1'b0;
   endtask

   task automatic do_update(input logic [31:0] pc, input logic tk, input logic [31:0] tg, input logic rt);
      upd_valid = 1'b1; upd_pc = pc; upd_taken = tk; upd_target = tg; upd_is_ret = rt;
      @(negedge clk);
      upd_valid = 1'b0;
   endtask

   task automatic do_call(input logic [31:0] pc);
      call_valid = 1'b1; call_pc = pc;
      @(negedge clk);
      call_valid = 1'b0;
   endtask

   task automatic t_reset();
      expect_pred("R1", 32'h0000_0100, 0, 0, 0, 32'h0000_0104);
      fetch_valid = 1'b0; fetch_pc = 32'h0000_0200;
      #2 chk("R2", "idle target", pred_target, 32'h0000_0204);
      chk("R2", "idle hit", 32'(pred_hit), 32'd0);
      @(negedge clk);
   endtask

   task automatic t_alloc();
      do_update(32'h0000_0200, 1'b0, 32'h0000_0880, 1'b0);
      expect_pred("R4", 32'h0000_0200, 0, 0, 0, 32'h0000_0204);
      do_update(32'h0000_0200, 1'b1, 32'h0000_0880, 1'b0);
      expect_pred("R5", 32'h0000_0200, 1, 1, 0, 32'h0000_0880);
      expect_pred("R3", 32'h0000_0300, 0, 0, 0, 32'h0000_0304);
   endtask

   task automatic t_counter();
      // counter is 2 now
      do_update(32'h0000_0200, 1'b0, 32'h0, 1'b0);            // 1
      expect_pred("R6", 32'h0000_0200, 1, 0, 0, 32'h0000_0204);
      do_update(32'h0000_0200, 1'b1, 32'h0000_0880, 1'b0);    // 2
      do_update(32'h0000_0200, 1'b1, 32'h0000_0880, 1'b0);    // 3
      do_update(32'h0000_0200, 1'b1, 32'h0000_0990, 1'b0);    // stays 3, target refreshed
      do_update(32'h0000_0200, 1'b0, 32'h0, 1'b0);            // 2
      expect_pred("R6", 32'h0000_0200, 1, 1, 0, 32'h0000_0990);
      do_update(32'h0000_0200, 1'b0, 32'h0, 1'b0);            // 1
      expect_pred("R6", 32'h0000_0200, 1, 0, 0, 32'h0000_0204);
      do_update(32'h0000_0200, 1'b0, 32'h0, 1'b0);            // 0
      do_update(32'h0000_0200, 1'b0, 32'h0, 1'b0);            // stays 0
      do_update(32'h0000_0200, 1'b1, 32'h0000_0990, 1'b0);    // 1
      expect_pred("R6", 32'h0000_0200, 1, 0, 0, 32'h0000_0204);
      do_update(32'h0000_0200, 1'b1, 32'h0000_0990, 1'b0);    // 2
      expect_pred("R6", 32'h0000_0200, 1, 1, 0, 32'h0000_0990);
   endtask

   task automatic t_same_cycle();
      upd_valid = 1'b1; upd_pc = 32'h0000_0040; upd_taken = 1'b1;
      upd_target = 32'h0000_9000; upd_is_ret = 1'b0;
      fetch_valid = 1'b1; fetch_pc = 32'h0000_0040;
      #2 chk("R11", "old contents hit", 32'(pred_hit), 32'd0);
      chk("R11", "old contents target", pred_target, 32'h0000_0044);
      @(negedge clk);
      upd_valid = 1'b0; fetch_valid = 1'b0;
      expect_pred("R11", 32'h0000_0040, 1, 1, 0, 32'h0000_9000);
   endtask

   task automatic t_returns();
      do_update(32'h0000_05A0, 1'b1, 32'h0, 1'b1);
      expect_pred("R9", 32'h0000_05A0, 0, 0, 0, 32'h0000_05A4);
      do_call(32'h0000_1000);
      do_call(32'h0000_2000);
      expect_pred("R7", 32'h0000_05A0, 1, 1, 1, 32'h0000_2004);
      expect_pred("R8", 32'h0000_05A0, 1, 1, 1, 32'h0000_1004);
      expect_pred("R9", 32'h0000_05A0, 0, 0, 0, 32'h0000_05A4);
   endtask

   task automatic t_overflow();
      for (int i = 0; i < 9; i++) do_call(32'h0000_3000 + 32'(i * 16));
      for (int i = 8; i >= 1; i--)
         expect_pred("R10", 32'h0000_05A0, 1, 1, 1, 32'h0000_3004 + 32'(i * 16));
      expect_pred("R10", 32'h0000_05A0, 0, 0, 0, 32'h0000_05A4);
   endtask

   task automatic t_push_pop();
      do_call(32'h0000_7000);
      call_valid = 1'b1; call_pc = 32'h0000_8000;
      expect_pred("R12", 32'h0000_05A0, 1, 1, 1, 32'h0000_7004);
      call_valid = 1'b0;
      expect_pred("R12", 32'h0000_05A0, 1, 1, 1, 32'h0000_8004);
      expect_pred("R12", 32'h0000_05A0, 0, 0, 0, 32'h0000_05A4);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_alloc();
      t_counter();
      t_same_cycle();
      t_returns();
      t_overflow();
      t_push_pop();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++;
         n_err++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule